// File: doc/BRIEF.md
# PLL Reprogramming Sequencer

This block applies a new divider configuration to the control fields of a fractional-N PLL. A start strobe captures the configuration: the integer and fractional feedback divider, the pre-divider, the target VCO frequency in MHz and the parent reference frequency in kHz. The block first derives the loop-filter gains. The integral gain and the gain row come from the VCO frequency band. The proportional gain is read from the chosen row at the column given by the reference frequency band.

The block then takes one of two paths. The short path applies when the PLL reports lock and both the integer divider and the pre-divider already hold the requested values. In that case the block rewrites only the fractional divider, and the loop stays undisturbed. In every other case the block runs the full path. It holds the PLL in reset, rewrites every control field one per cycle in a fixed order, releases reset, and waits for lock. The wait is bounded by a poll budget measured in microsecond ticks. Every request ends in a one-cycle done pulse that carries a two-bit result code.

Top module: `pll_reprog_seq`

## Requirements
- R1: A start pulse is accepted only while `busy` is low, and the configuration is captured in that cycle. `busy` stays high from the next cycle up to and including the single-cycle `done` pulse. A start pulse during that time has no effect on the result or on the number of done pulses.
- R2: The VCO frequency selects the gains. At 700 MHz or above and below 2200 MHz: integral gain 4 and the mid row. At 2200 MHz or above and below 3100 MHz: integral gain 3 and the high row. At 3100 MHz or above and below 4000 MHz: integral gain 3 and the top row. Any other frequency finishes with code 1 and leaves every control output unchanged.
- R3: The reference frequency is the parent frequency divided by the pre-divider. A pre-divider of 0 doubles the parent frequency instead.
- R4: The reference frequency selects one of eight columns. Column k covers the range from its lower edge up to, but not including, the next edge. The lower edges are 10000, 12500, 15000, 20000, 25000, 50000, 75000 and 100000 kHz. The proportional gain per column is 5,6,6,7,7,8,9,10 in the mid row, 4,4,5,5,6,7,8,9 in the high row and 4,5,5,6,7,8,9,10 in the top row.
- R5: A reference frequency below 10000 kHz, or at or above 125000 kHz, finishes with code 2 and leaves every control output unchanged.
- R6: The short path is taken only when lock is high and both the current integer divider and the current pre-divider equal the requested values. On this path only `ndiv_frac_o` changes, the PLL reset is never driven to its hold pattern, and the code is 0.
- R7: The full path first drives the hold pattern on the reset pair. It then sets the mode field to 7, clears the upper VCO control word and updates the lower VCO word. Bit 30 of the lower word is set when the frequency is below 1200 MHz and is never cleared by the block. Bit 19 is set at or above 2200 MHz and cleared below that. The integer divider, the fraction and the pre-divider are written last, all while reset is held and the mode field already reads 7.
- R8: After the dividers, the full path writes the proportional and integral gains and a derivative gain of 0, and then drives the release pattern. With `RST_SET_HOLDS` = 1, the hold pattern is 2'b11 and the release pattern is 2'b00; with 0, the patterns are swapped. After reset, the pair shows the hold pattern.
- R9: After the release, a lock seen before `LOCK_TRIES` × `POLL_US` microsecond ticks finishes with code 0. If no lock is seen in that time, the request finishes with code 3 and the reset pair stays in the release pattern.
- R10: After reset, `busy`, `done` and `err_o` are 0, the mode field and both dividers are 0, the lower VCO word is 0 and the upper VCO word equals `VCO_HI_INIT`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Request strobe |
| cfg_vco_mhz | input | VCO_W | Target VCO frequency in MHz |
| cfg_parent_khz | input | PAR_W | Parent reference frequency in kHz |
| cfg_ndiv_int | input | NINT_W | Requested integer feedback divider |
| cfg_ndiv_frac | input | NFRAC_W | Requested fractional feedback divider |
| cfg_pdiv | input | PDIV_W | Requested pre-divider (0 = double) |
| lock | input | 1 | PLL lock status |
| us_tick | input | 1 | One-cycle pulse every microsecond |
| pll_rst_o | output | 2 | Reset pair driven to the PLL |
| mode_o | output | 3 | Macro mode field |
| vco_hi_o | output | 32 | Upper VCO control word |
| vco_lo_o | output | 32 | Lower VCO control word (bits 30 and 19 used) |
| ndiv_int_o | output | NINT_W | Integer divider field |
| ndiv_frac_o | output | NFRAC_W | Fractional divider field |
| pdiv_o | output | PDIV_W | Pre-divider field |
| kp_o | output | 4 | Proportional gain |
| ki_o | output | 3 | Integral gain |
| ka_o | output | 3 | Derivative gain |
| busy | output | 1 | Request in progress |
| done | output | 1 | Single-cycle completion pulse |
| err_o | output | 2 | Result code: 0 ok, 1 VCO range, 2 reference range, 3 lock timeout |

## Verification
The bench builds the block with `LOCK_TRIES` = 4 and `POLL_US` = 3, so the lock timeout is only twelve ticks long. With these values the timeout and its retry are reached within a few dozen cycles. It keeps `RST_SET_HOLDS` = 1 and the default field widths, so the hold pattern 2'b11 can be checked directly. The range of the widths also covers every VCO edge, every reference column edge and the doubling case with a pre-divider of 0. A PLL model that asserts lock a few cycles after release, and that can be told never to lock, makes both outcomes of the short-path decision reachable.

// File: rtl/pll_seq_pkg.sv
package pll_seq_pkg;

   typedef enum logic [3:0] {
      S_IDLE, S_CHECK, S_FRAC, S_HOLD, S_MODE, S_VHI, S_VLO,
      S_NINT, S_NFRAC, S_PDIV, S_GAIN, S_REL, S_WAIT, S_DONE
   } seq_state_t;

   typedef enum logic [1:0] {
      ERR_NONE = 2'd0, ERR_VCO = 2'd1, ERR_REF = 2'd2, ERR_LOCK = 2'd3
   } seq_err_t;

   typedef enum logic [1:0] {
      ROW_MID = 2'd0, ROW_HIGH = 2'd1, ROW_TOP = 2'd2
   } gain_row_t;

   // VCO band edges in MHz
   localparam int unsigned VCO_MIN_MHZ  = 700;
   localparam int unsigned VCO_LOWB_MHZ = 1200;
   localparam int unsigned VCO_HIB_MHZ  = 2200;
   localparam int unsigned VCO_TOPB_MHZ = 3100;
   localparam int unsigned VCO_MAX_MHZ  = 4000;

   // reference column edges in kHz; the last entry closes the top column
   localparam int unsigned REF_EDGE_KHZ [9] = '{
      10000, 12500, 15000, 20000, 25000, 50000, 75000, 100000, 125000
   };

   localparam logic [3:0] KP_TBL [3][8] = '{
      '{4'd5, 4'd6, 4'd6, 4'd7, 4'd7, 4'd8, 4'd9, 4'd10},
      '{4'd4, 4'd4, 4'd5, 4'd5, 4'd6, 4'd7, 4'd8, 4'd9},
      '{4'd4, 4'd5, 4'd5, 4'd6, 4'd7, 4'd8, 4'd9, 4'd10}
   };

   localparam logic [2:0] USER_MODE = 3'd7;
   localparam int         LOWV_BIT  = 30;
   localparam int         HIGHV_BIT = 19;

endpackage

// File: rtl/pll_gain_sel.sv
module pll_gain_sel
   import pll_seq_pkg::*;
#(
   parameter int VCO_W  = 12,
   parameter int PAR_W  = 20,
   parameter int PDIV_W = 4
) (
   input  logic [VCO_W-1:0]  vco_mhz,
   input  logic [PAR_W-1:0]  parent_khz,
   input  logic [PDIV_W-1:0] pdiv,
   output logic [3:0]        kp,
   output logic [2:0]        ki,
   output logic              vco_bad,
   output logic              ref_bad,
   output logic              below_mid,
   output logic              at_high
);
   localparam int REF_W = PAR_W + 1;

   if (REF_W > 32) begin : g_bad_par
      $error("PAR_W must be at most 31");
   end
   if (PDIV_W >= REF_W) begin : g_bad_pdiv
      $error("PDIV_W must be narrower than PAR_W + 1");
   end

   logic [REF_W-1:0] ref_khz;
   logic [31:0]      v32, r32;
   gain_row_t        row;
   logic [2:0]       col;

   always_comb begin
      if (pdiv == '0) ref_khz = {parent_khz, 1'b0};
      else            ref_khz = {1'b0, parent_khz} / {{(REF_W-PDIV_W){1'b0}}, pdiv};
      v32 = 32'(vco_mhz);
      r32 = 32'(ref_khz);

      vco_bad = 1'b0;
      if (v32 >= VCO_MIN_MHZ && v32 < VCO_HIB_MHZ) begin
         row = ROW_MID;  ki = 3'd4;
      end else if (v32 >= VCO_HIB_MHZ && v32 < VCO_TOPB_MHZ) begin
         row = ROW_HIGH; ki = 3'd3;
      end else begin
         row = ROW_TOP;  ki = 3'd3;
         vco_bad = !(v32 >= VCO_TOPB_MHZ && v32 < VCO_MAX_MHZ);
      end

      col = 3'd0;
      for (int i = 1; i < 8; i++)
         if (r32 >= REF_EDGE_KHZ[i]) col = 3'(i);
      ref_bad = (r32 < REF_EDGE_KHZ[0]) || (r32 >= REF_EDGE_KHZ[8]);
      kp      = KP_TBL[row][col];

      below_mid = v32 < VCO_LOWB_MHZ;
      at_high   = v32 >= VCO_HIB_MHZ;
   end
endmodule

// File: rtl/pll_lock_timer.sv
module pll_lock_timer #(
   parameter int LOCK_TRIES = 100,
   parameter int POLL_US    = 10
) (
   input  logic clk,
   input  logic rst_n,
   input  logic clear,
   input  logic us_tick,
   output logic expired
);
   localparam int TW = $clog2(LOCK_TRIES + 1);
   localparam int SW = $clog2(POLL_US + 1);

   if (LOCK_TRIES < 1 || POLL_US < 1) begin : g_bad_cfg
      $error("LOCK_TRIES and POLL_US must be at least 1");
   end

   logic [SW-1:0] sub_cnt;
   logic [TW-1:0] poll_cnt;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sub_cnt  <= '0;
         poll_cnt <= '0;
      end else if (clear) begin
         sub_cnt  <= '0;
         poll_cnt <= '0;
      end else if (us_tick && !expired) begin
         if (sub_cnt == SW'(POLL_US - 1)) begin
            sub_cnt  <= '0;
            poll_cnt <= poll_cnt + 1'b1;
         end else begin
            sub_cnt <= sub_cnt + 1'b1;
         end
      end
   end

   assign expired = (poll_cnt == TW'(LOCK_TRIES));
endmodule

// File: rtl/pll_reprog_seq.sv
module pll_reprog_seq
   import pll_seq_pkg::*;
#(
   parameter int          VCO_W         = 12,
   parameter int          PAR_W         = 20,
   parameter int          NINT_W        = 10,
   parameter int          NFRAC_W       = 20,
   parameter int          PDIV_W        = 4,
   parameter int          LOCK_TRIES    = 100,
   parameter int          POLL_US       = 10,
   parameter bit          RST_SET_HOLDS = 1'b1,
   parameter logic [31:0] VCO_HI_INIT   = 32'hFFFF_FFFF
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               start,
   input  logic [VCO_W-1:0]   cfg_vco_mhz,
   input  logic [PAR_W-1:0]   cfg_parent_khz,
   input  logic [NINT_W-1:0]  cfg_ndiv_int,
   input  logic [NFRAC_W-1:0] cfg_ndiv_frac,
   input  logic [PDIV_W-1:0]  cfg_pdiv,
   input  logic               lock,
   input  logic               us_tick,
   output logic [1:0]         pll_rst_o,
   output logic [2:0]         mode_o,
   output logic [31:0]        vco_hi_o,
   output logic [31:0]        vco_lo_o,
   output logic [NINT_W-1:0]  ndiv_int_o,
   output logic [NFRAC_W-1:0] ndiv_frac_o,
   output logic [PDIV_W-1:0]  pdiv_o,
   output logic [3:0]         kp_o,
   output logic [2:0]         ki_o,
   output logic [2:0]         ka_o,
   output logic               busy,
   output logic               done,
   output logic [1:0]         err_o
);
   if (NINT_W < 1 || NFRAC_W < 1 || PDIV_W < 1 || VCO_W < 12) begin : g_bad_w
      $error("field widths too small");
   end

   logic [1:0] rst_hold, rst_free;
   if (RST_SET_HOLDS) begin : g_hold_ones
      assign rst_hold = 2'b11;
      assign rst_free = 2'b00;
   end else begin : g_hold_zeros
      assign rst_hold = 2'b00;
      assign rst_free = 2'b11;
   end

   seq_state_t         state;
   logic [VCO_W-1:0]   c_vco;
   logic [PAR_W-1:0]   c_par;
   logic [NINT_W-1:0]  c_nint;
   logic [NFRAC_W-1:0] c_frac;
   logic [PDIV_W-1:0]  c_pdiv;

   logic [3:0] kp_sel;
   logic [2:0] ki_sel;
   logic       vco_bad, ref_bad, below_mid, at_high, expired;

   pll_gain_sel #(.VCO_W(VCO_W), .PAR_W(PAR_W), .PDIV_W(PDIV_W)) u_gain (
      .vco_mhz(c_vco), .parent_khz(c_par), .pdiv(c_pdiv),
      .kp(kp_sel), .ki(ki_sel), .vco_bad(vco_bad), .ref_bad(ref_bad),
      .below_mid(below_mid), .at_high(at_high)
   );

   pll_lock_timer #(.LOCK_TRIES(LOCK_TRIES), .POLL_US(POLL_US)) u_timer (
      .clk(clk), .rst_n(rst_n), .clear(state != S_WAIT),
      .us_tick(us_tick), .expired(expired)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state       <= S_IDLE;
         c_vco       <= '0;
         c_par       <= '0;
         c_nint      <= '0;
         c_frac      <= '0;
         c_pdiv      <= '0;
         pll_rst_o   <= rst_hold;
         mode_o      <= '0;
         vco_hi_o    <= VCO_HI_INIT;
         vco_lo_o    <= '0;
         ndiv_int_o  <= '0;
         ndiv_frac_o <= '0;
         pdiv_o      <= '0;
         kp_o        <= '0;
         ki_o        <= '0;
         ka_o        <= '0;
         err_o       <= ERR_NONE;
      end else begin
         case (state)
            S_IDLE: if (start) begin
               c_vco  <= cfg_vco_mhz;
               c_par  <= cfg_parent_khz;
               c_nint <= cfg_ndiv_int;
               c_frac <= cfg_ndiv_frac;
               c_pdiv <= cfg_pdiv;
               state  <= S_CHECK;
            end
            S_CHECK: begin
               if (vco_bad) begin
                  err_o <= ERR_VCO;
                  state <= S_DONE;
               end else if (ref_bad) begin
                  err_o <= ERR_REF;
                  state <= S_DONE;
               end else if (lock && ndiv_int_o == c_nint && pdiv_o == c_pdiv) begin
                  state <= S_FRAC;
               end else begin
                  state <= S_HOLD;
               end
            end
            S_FRAC: begin
               ndiv_frac_o <= c_frac;
               err_o       <= ERR_NONE;
               state       <= S_DONE;
            end
            S_HOLD:  begin pll_rst_o <= rst_hold;  state <= S_MODE;  end
            S_MODE:  begin mode_o    <= USER_MODE; state <= S_VHI;   end
            S_VHI:   begin vco_hi_o  <= '0;        state <= S_VLO;   end
            S_VLO: begin
               if (below_mid) vco_lo_o[LOWV_BIT] <= 1'b1;
               vco_lo_o[HIGHV_BIT] <= at_high;
               state <= S_NINT;
            end
            S_NINT:  begin ndiv_int_o  <= c_nint; state <= S_NFRAC; end
            S_NFRAC: begin ndiv_frac_o <= c_frac; state <= S_PDIV;  end
            S_PDIV:  begin pdiv_o      <= c_pdiv; state <= S_GAIN;  end
            S_GAIN: begin
               kp_o  <= kp_sel;
               ki_o  <= ki_sel;
               ka_o  <= '0;
               state <= S_REL;
            end
            S_REL:   begin pll_rst_o <= rst_free; state <= S_WAIT; end
            S_WAIT: begin
               if (lock) begin
                  err_o <= ERR_NONE;
                  state <= S_DONE;
               end else if (expired) begin
                  err_o <= ERR_LOCK;
                  state <= S_DONE;
               end
            end
            S_DONE:  state <= S_IDLE;
            default: state <= S_IDLE;
         endcase
      end
   end

   assign busy = (state != S_IDLE);
   assign done = (state == S_DONE);
endmodule

// File: rtl/pll_reprog_seq_chk.sv
module pll_reprog_seq_chk #(
   parameter int NINT_W        = 10,
   parameter bit RST_SET_HOLDS = 1'b1
) (
   input logic              clk,
   input logic              rst_n,
   input logic              busy,
   input logic              done,
   input logic [1:0]        err_o,
   input logic [1:0]        pll_rst_o,
   input logic [NINT_W-1:0] ndiv_int_o
);
   localparam logic [1:0] FREE_PAT = RST_SET_HOLDS ? 2'b00 : 2'b11;

   // R1
   done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done);

   // R1
   busy_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(busy) |-> $past(done));

   // R1
   idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !busy |=> $stable(ndiv_int_o));

   // R5
   range_err_rst_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (done && (err_o == 2'd1 || err_o == 2'd2)) |-> $stable(pll_rst_o));

   // R9
   timeout_free_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (done && err_o == 2'd3) |-> (pll_rst_o == FREE_PAT));
endmodule

bind pll_reprog_seq pll_reprog_seq_chk #(
   .NINT_W(NINT_W), .RST_SET_HOLDS(RST_SET_HOLDS)
) i_chk (
   .clk(clk), .rst_n(rst_n), .busy(busy), .done(done), .err_o(err_o),
   .pll_rst_o(pll_rst_o), .ndiv_int_o(ndiv_int_o)
);

// File: tb/test_pll_reprog_seq.sv
`timescale 1ns/1ps
module test_pll_reprog_seq;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        start = 1'b0;
   logic [11:0] cfg_vco_mhz = '0;
   logic [19:0] cfg_parent_khz = '0;
   logic [9:0]  cfg_ndiv_int = '0;
   logic [19:0] cfg_ndiv_frac = '0;
   logic [3:0]  cfg_pdiv = '0;
   logic        lock = 1'b0;
   logic        us_tick = 1'b0;
   logic [1:0]  pll_rst_o;
   logic [2:0]  mode_o, ki_o, ka_o;
   logic [31:0] vco_hi_o, vco_lo_o;
   logic [9:0]  ndiv_int_o;
   logic [19:0] ndiv_frac_o;
   logic [3:0]  pdiv_o, kp_o;
   logic        busy, done;
   logic [1:0]  err_o;

   int checks = 0, errors = 0;
   bit no_lock = 1'b0;
   int lock_cnt = 0;
   bit hold_seen;
   logic [1:0] rst_at_nint;
   logic [2:0] mode_at_nint;
   logic [9:0] prev_nint = '0;
   int done_cnt = 0;

   always #2.5 clk = ~clk;

   pll_reprog_seq #(.LOCK_TRIES(4), .POLL_US(3)) i_pll_reprog_seq (
      .clk(clk), .rst_n(rst_n), .start(start), .cfg_vco_mhz(cfg_vco_mhz),
      .cfg_parent_khz(cfg_parent_khz), .cfg_ndiv_int(cfg_ndiv_int),
      .cfg_ndiv_frac(cfg_ndiv_frac), .cfg_pdiv(cfg_pdiv), .lock(lock),
      .us_tick(us_tick), .pll_rst_o(pll_rst_o), .mode_o(mode_o),
      .vco_hi_o(vco_hi_o), .vco_lo_o(vco_lo_o), .ndiv_int_o(ndiv_int_o),
      .ndiv_frac_o(ndiv_frac_o), .pdiv_o(pdiv_o), .kp_o(kp_o), .ki_o(ki_o),
      .ka_o(ka_o), .busy(busy), .done(done), .err_o(err_o)
   );

   // PLL model, tick source and observers, all on the falling edge
   always @(negedge clk) begin
      us_tick = ~us_tick;
      if (pll_rst_o != 2'b00) begin
         lock_cnt = 0;
         lock = 1'b0;
      end else begin
         if (lock_cnt < 6) lock_cnt++;
         lock = (lock_cnt >= 6) && !no_lock;
      end
      if (ndiv_int_o !== prev_nint) begin
         rst_at_nint  = pll_rst_o;
         mode_at_nint = mode_o;
      end
      prev_nint = ndiv_int_o;
      if (busy && pll_rst_o == 2'b11) hold_seen = 1'b1;
      if (done) done_cnt++;
   end

   task automatic chk(input string tag, input longint act, input longint exp);
      checks++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
      end
   endtask

   task automatic run(input int vco, input int par, input int pd,
                      input int nint, input int frac, output int e);
      int n = 0;
      @(negedge clk);
      cfg_vco_mhz = 12'(vco); cfg_parent_khz = 20'(par); cfg_pdiv = 4'(pd);
      cfg_ndiv_int = 10'(nint); cfg_ndiv_frac = 20'(frac);
      hold_seen = 1'b0;
      start = 1'b1;
      @(negedge clk);
      start = 1'b0;
      while (!done && n < 400) begin
         @(negedge clk);
         n++;
      end
      e = done ? int'(err_o) : -1;
   endtask

   task automatic t_reset;
      chk("R10 busy", busy, 0);
      chk("R10 done", done, 0);
      chk("R10 err", err_o, 0);
      chk("R8 reset pair holds", pll_rst_o, 3);
      chk("R10 mode", mode_o, 0);
      chk("R10 nint", ndiv_int_o, 0);
      chk("R10 vco hi", vco_hi_o, 32'hFFFF_FFFF);
      chk("R10 vco lo", vco_lo_o, 0);
   endtask

   task automatic t_full_mid;
      int e;
      run(1000, 25000, 1, 40, 5, e);
      chk("R9 code ok", e, 0);
      chk("R1 busy at done", busy, 1);
      chk("R2 ki mid", ki_o, 4);
      chk("R4 kp col4 mid", kp_o, 7);
      chk("R8 ka zero", ka_o, 0);
      chk("R8 released", pll_rst_o, 0);
      chk("R7 mode", mode_o, 7);
      chk("R7 hi cleared", vco_hi_o, 0);
      chk("R7 bit30", vco_lo_o[30], 1);
      chk("R7 bit19", vco_lo_o[19], 0);
      chk("R7 nint", ndiv_int_o, 40);
      chk("R7 frac", ndiv_frac_o, 5);
      chk("R7 pdiv", pdiv_o, 1);
      chk("R7 rst held at nint", rst_at_nint, 3);
      chk("R7 mode before nint", mode_at_nint, 7);
      @(negedge clk);
      chk("R1 busy dropped", busy, 0);
   endtask

   task automatic t_frac_only;
      int e;
      run(1000, 25000, 1, 40, 77, e);
      chk("R6 code", e, 0);
      chk("R6 frac", ndiv_frac_o, 77);
      chk("R6 no hold", hold_seen, 0);
      chk("R6 nint kept", ndiv_int_o, 40);
   endtask

   task automatic t_high_top;
      int e;
      run(2500, 12500, 1, 200, 9, e);
      chk("R2 high code", e, 0);
      chk("R6 nint differs -> hold", hold_seen, 1);
      chk("R2 ki high", ki_o, 3);
      chk("R4 kp col1 high", kp_o, 4);
      chk("R7 bit19 set", vco_lo_o[19], 1);
      chk("R7 bit30 sticky", vco_lo_o[30], 1);
      run(3500, 60000, 0, 60, 1, e);
      chk("R3 doubled code", e, 0);
      chk("R3 kp col7 top", kp_o, 10);
      chk("R2 ki top", ki_o, 3);
      chk("R3 pdiv zero", pdiv_o, 0);
   endtask

   task automatic t_vco_range;
      int e;
      run(699, 25000, 1, 11, 1, e);
      chk("R2 below 700", e, 1);
      chk("R2 nint unchanged", ndiv_int_o, 60);
      run(4000, 25000, 1, 12, 1, e);
      chk("R2 at 4000", e, 1);
      run(2199, 25000, 1, 13, 1, e);
      chk("R2 2199 ok", e, 0);
      chk("R2 2199 ki", ki_o, 4);
      chk("R7 2199 bit19", vco_lo_o[19], 0);
      run(2200, 25000, 1, 14, 1, e);
      chk("R2 2200 ki", ki_o, 3);
      chk("R4 2200 kp col4 high", kp_o, 6);
   endtask

   task automatic t_ref_range;
      int e;
      run(1000, 9999, 1, 15, 1, e);
      chk("R5 below 10 MHz", e, 2);
      chk("R5 nint unchanged", ndiv_int_o, 14);
      run(1000, 250000, 2, 16, 1, e);
      chk("R5 at 125 MHz", e, 2);
      run(1000, 12499, 1, 17, 1, e);
      chk("R4 12499 kp", kp_o, 5);
      run(1000, 25000, 2, 18, 1, e);
      chk("R4 12500 kp", kp_o, 6);
      run(1000, 124999, 1, 19, 1, e);
      chk("R4 124999 kp", kp_o, 10);
   endtask

   task automatic t_timeout;
      int e;
      no_lock = 1'b1;
      run(1000, 25000, 1, 30, 2, e);
      chk("R9 timeout code", e, 3);
      chk("R9 released", pll_rst_o, 0);
      run(1000, 25000, 1, 30, 3, e);
      chk("R6 unlocked takes full path", hold_seen, 1);
      chk("R9 second timeout", e, 3);
      no_lock = 1'b0;
      repeat (10) @(negedge clk);
   endtask

   task automatic t_busy_start;
      int e, n = 0;
      @(negedge clk);
      cfg_vco_mhz = 12'd1000; cfg_parent_khz = 20'd25000; cfg_pdiv = 4'd1;
      cfg_ndiv_int = 10'd50; cfg_ndiv_frac = 20'd3;
      done_cnt = 0;
      start = 1'b1;
      @(negedge clk);
      start = 1'b0;
      repeat (2) @(negedge clk);
      cfg_ndiv_int = 10'd99; start = 1'b1;
      @(negedge clk);
      start = 1'b0;
      while (!done && n < 400) begin
         @(negedge clk);
         n++;
      end
      e = int'(err_o);
      chk("R1 first request wins", ndiv_int_o, 50);
      chk("R1 code", e, 0);
      repeat (40) @(negedge clk);
      chk("R1 single done", done_cnt, 1);
      chk("R1 idle after", busy, 0);
   endtask

   initial begin
      #(5.0 * 150000);
      errors++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      t_reset();
      rst_n = 1'b1;
      repeat (2) @(negedge clk);
      t_full_mid();
      t_frac_only();
      t_high_top();
      t_vco_range();
      t_ref_range();
      t_timeout();
      t_busy_start();
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end
endmodule